// File: doc/BRIEF.md
# MDIO Station Management Master

This block drives read and write register transactions to an external Ethernet PHY over the two-wire management bus. It has a clock output (MDC) and a bidirectional data line. The data line appears as three separate signals: output value, output enable and input. A command carries a direction bit, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block accepts a command only while it is idle. It then sends one 64-bit frame and shows a busy flag for the whole frame.

A 4-bit range code selects the MDC divide ratio from the register clock. The code is latched together with the command. Codes 0 to 5 give slow ratios meant for different register-clock bands. Codes 8 to 15 give fast ratios in even steps. The reserved codes fall back to the default ratio. For a read, the block releases the data line from the turnaround onwards and samples the PHY on each MDC rising edge. The 16-bit result is ready when busy drops.

Top module: `mdio_master`

## Requirements
- R1: The latched range code sets the number of register-clock cycles per MDC period: code 0 gives 42, 1 gives 62, 2 gives 16, 3 gives 26, 4 gives 102 and 5 gives 124.
- R2: Codes 8 to 15 give 4, 6, 8, 10, 12, 14, 16 and 18 cycles per MDC period. Codes 6 and 7 give 42.
- R3: Each MDC period is low for its first half and high for its second half. Every frame has exactly 64 MDC periods, and MDC is low while idle.
- R4: A write frame on the data line, MSB first, is 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 write-data bits. The line is driven in all 64 periods.
- R5: cmd_write_i = 0 requests a read. A read frame sends 32 ones, start 01, opcode 10, PHY address and register address, which makes 46 driven periods.
- R6: In a read, mdio_oe_o is 0 for periods 46 to 63. The bit present on mdio_i at the MDC rising edge of periods 48 to 63 is shifted into rdata_o, MSB first. rdata_o holds the value once busy_o falls.
- R7: busy_o is 1 from the first clock edge after a command is accepted (cmd_valid_i high while busy_o is 0). It stays 1 for exactly 64 times the divide ratio, in clock cycles.
- R8: A command presented while busy_o is 1 is ignored. The running frame keeps its fields, and no second frame follows.
- R9: While idle and during reset, busy_o = 0, mdc_o = 0, mdio_oe_o = 0 and mdio_o = 1.
- R10: Changing range_i while a frame is running has no effect on that frame's MDC timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| range_i | input | 4 | MDC divide range code, latched on accept |
| cmd_valid_i | input | 1 | Command request |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_phy_i | input | 5 | PHY address |
| cmd_reg_i | input | 5 | Register address |
| cmd_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | 1 while a frame is in progress |
| rdata_o | output | 16 | Read result, valid after a read ends |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
busy_o is due at the first clock edge after the accepting edge. It falls exactly 64 times the divide ratio cycles later, so the bench counts cycles between those two points rather than waiting on the flag. Frame bits, the output-enable pattern and the MDC period are observed on MDC rising edges, which are detected by sampling on the falling register-clock edge. This ties the checks to MDC events and not to fixed cycle offsets. The PHY model drives read data at MDC falling edges, and rdata_o is compared only after busy_o has dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DIV_W = 7;

  typedef enum logic {
    MDIO_OP_READ  = 1'b0,
    MDIO_OP_WRITE = 1'b1
  } mdio_op_e;

  function automatic logic [DIV_W-1:0] div_for_code(input logic [3:0] code);
    logic [DIV_W-1:0] d;
    if (code[3]) begin
      d = DIV_W'(4) + DIV_W'({code[2:0], 1'b0});
    end else begin
      case (code[2:0])
        3'd1:    d = DIV_W'(62);
        3'd2:    d = DIV_W'(16);
        3'd3:    d = DIV_W'(26);
        3'd4:    d = DIV_W'(102);
        3'd5:    d = DIV_W'(124);
        default: d = DIV_W'(42); // 0 and reserved 6, 7
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half;

  assign half   = div_i >> 1;
  assign rise_o = run_i && (cnt_q == half - DIV_W'(1));
  assign fall_o = run_i && (cnt_q == div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + DIV_W'(1);
      if (rise_o)      mdc_o <= 1'b1;
      else if (fall_o) mdc_o <= 1'b0;
    end
  end

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < div_i);
  a_r3_low_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && cnt_q < half |-> !mdc_o);
  a_r3_rise_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> mdc_o);
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32,
  parameter int RANGE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic               cmd_write_i,
  input  logic [ADDR_W-1:0]  cmd_phy_i,
  input  logic [ADDR_W-1:0]  cmd_reg_i,
  input  logic [DATA_W-1:0]  cmd_wdata_i,
  input  logic [RANGE_W-1:0] range_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdio_i,
  output logic               busy_o,
  output logic [DIV_W-1:0]   div_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int FRAME_LEN = PRE_LEN + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int REL_IDX   = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_IDX  = REL_IDX + 2;

  logic                 busy_q;
  mdio_op_e             op_q;
  logic [DIV_W-1:0]     div_q;
  logic [IDX_W-1:0]     bit_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [DATA_W-1:0]    rdata_q;
  logic                 accept;
  logic [FRAME_LEN-1:0] frame_w;

  assign accept  = cmd_valid_i && !busy_q;
  assign frame_w = {{PRE_LEN{1'b1}}, 2'b01,
                    (cmd_write_i ? 2'b01 : 2'b10),
                    cmd_phy_i, cmd_reg_i, 2'b10, cmd_wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= MDIO_OP_READ;
      div_q  <= div_for_code('0);
      bit_q  <= '0;
      sh_q   <= '1;
    end else if (accept) begin
      busy_q <= 1'b1;
      op_q   <= mdio_op_e'(cmd_write_i);
      div_q  <= div_for_code(4'(range_i));
      bit_q  <= '0;
      sh_q   <= frame_w;
    end else if (busy_q && fall_i) begin
      sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
      bit_q <= bit_q + IDX_W'(1);
      if (bit_q == IDX_W'(FRAME_LEN - 1)) busy_q <= 1'b0;
    end
  end

  // read capture on MDC rising edge, data phase only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (busy_q && op_q == MDIO_OP_READ && rise_i && bit_q >= IDX_W'(DATA_IDX)) begin
      rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
    end
  end

  assign busy_o    = busy_q;
  assign div_o     = div_q;
  assign rdata_o   = rdata_q;
  assign mdio_o    = busy_q ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe_o = busy_q && (op_q == MDIO_OP_WRITE || bit_q < IDX_W'(REL_IDX));

  a_r7_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !busy_q |=> busy_q);
  a_r8_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(op_q) && $stable(div_q));
  a_r10_div_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !$stable(range_i) |=> $stable(div_q) || !$past(busy_q));
  a_r6_rdata_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> $stable(rdata_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32,
  parameter int RANGE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RANGE_W-1:0] range_i,
  input  logic               cmd_valid_i,
  input  logic               cmd_write_i,
  input  logic [ADDR_W-1:0]  cmd_phy_i,
  input  logic [ADDR_W-1:0]  cmd_reg_i,
  input  logic [DATA_W-1:0]  cmd_wdata_i,
  output logic               busy_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               mdc_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  input  logic               mdio_i
);
  logic [DIV_W-1:0] div;
  logic             rise;
  logic             fall;

  mdio_frame_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PRE_LEN(PRE_LEN),
    .RANGE_W(RANGE_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_write_i(cmd_write_i),
    .cmd_phy_i  (cmd_phy_i),
    .cmd_reg_i  (cmd_reg_i),
    .cmd_wdata_i(cmd_wdata_i),
    .range_i    (range_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .mdio_i     (mdio_i),
    .busy_o     (busy_o),
    .div_o      (div),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .rdata_o    (rdata_o)
  );

  mdio_clk_div #(
    .DIV_W(DIV_W)
  ) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_o),
    .div_i (div),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdc_o && !mdio_oe_o && mdio_o);
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  range_i = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [4:0]  cmd_phy = '0;
  logic [4:0]  cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic        busy;
  logic [15:0] rdata;
  logic        mdc;
  logic        mdio_out;
  logic        mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0;
  int errors = 0;

  // PHY-side monitor state
  int          cyc_n = 0;
  int          rises = 0;
  int          highs = 0;
  int          period_bad = 0;
  int          last_rise = 0;
  int          cur_div = 42;
  logic        mdc_prev = 1'b0;
  logic [63:0] cap = '0;
  logic [63:0] oecap = '0;
  logic [15:0] phy_word = '0;

  always #(CLK_P/2) clk = ~clk;

  mdio_master dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .range_i    (range_i),
    .cmd_valid_i(cmd_valid),
    .cmd_write_i(cmd_write),
    .cmd_phy_i  (cmd_phy),
    .cmd_reg_i  (cmd_reg),
    .cmd_wdata_i(cmd_wdata),
    .busy_o     (busy),
    .rdata_o    (rdata),
    .mdc_o      (mdc),
    .mdio_o     (mdio_out),
    .mdio_oe_o  (mdio_oe),
    .mdio_i     (mdio_in)
  );

  always @(negedge clk) begin
    cyc_n++;
    if (mdc && !mdc_prev) begin
      cap   = {cap[62:0], mdio_out};
      oecap = {oecap[62:0], mdio_oe};
      if (rises > 0 && (cyc_n - last_rise) != cur_div) period_bad++;
      last_rise = cyc_n;
      rises++;
    end
    if (!mdc && mdc_prev) begin
      if (rises == 47)                     mdio_in = 1'b0;
      else if (rises >= 48 && rises <= 63) mdio_in = phy_word[63 - rises];
      else                                 mdio_in = 1'b1;
    end
    if (mdc) highs++;
    mdc_prev = mdc;
  end

  function automatic int exp_div(input int c);
    if (c >= 8) return 4 + 2 * (c - 8);
    case (c)
      0: return 42;
      1: return 62;
      2: return 16;
      3: return 26;
      4: return 102;
      5: return 124;
      default: return 42;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic txn(input int code, input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                     input logic [15:0] wd, input logic [15:0] pd, input bit inj, input bit chg,
                     input string rdiv);
    int n;
    logic [63:0] exp_f;
    logic [63:0] exp_oe;
    cur_div = exp_div(code);
    phy_word = pd;
    rises = 0; highs = 0; period_bad = 0; cap = '0; oecap = '0;
    @(negedge clk);
    range_i = 4'(code); cmd_write = wr; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy && n < 20000) begin
      n++;
      if (inj && n == 3) begin
        cmd_valid = 1'b1; cmd_write = ~wr; cmd_phy = ~phy; cmd_reg = ~rg; cmd_wdata = ~wd;
      end
      if (inj && n == 5) cmd_valid = 1'b0;
      if (chg && n == 7) range_i = (code == 8) ? 4'd5 : 4'd8;
      @(negedge clk);
    end
    @(negedge clk);
    chk(n == 64 * cur_div, "R7 busy length", 64'(n), 64'(64 * cur_div));
    chk(rises == 64, "R3 MDC period count", 64'(rises), 64'd64);
    chk(highs == 32 * cur_div, "R3 MDC high time", 64'(highs), 64'(32 * cur_div));
    chk(period_bad == 0, {rdiv, " MDC period"}, 64'(period_bad), 64'd0);
    exp_f = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, wd};
    if (wr) begin
      chk(cap == exp_f, "R4 write frame", cap, exp_f);
      chk(oecap == '1, "R4 write drive", oecap, '1);
    end else begin
      exp_oe = {{46{1'b1}}, 18'b0};
      chk(cap[63:18] == exp_f[63:18], "R5 read header", cap, exp_f);
      chk(oecap == exp_oe, "R6 read release", oecap, exp_oe);
      chk(rdata == pd, "R6 read data", 64'(rdata), 64'(pd));
    end
    chk(!busy && !mdc && !mdio_oe && mdio_out, "R9 idle after frame",
        64'({busy, mdc, mdio_oe, mdio_out}), 64'b0001);
    if (inj) begin
      repeat (10) @(negedge clk);
      chk(!busy && rises == 64, "R8 no second frame", 64'({busy, 7'(rises)}), 64'd64);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mdc && !mdio_oe && mdio_out && rdata == 16'h0, "R9 reset state",
        64'({busy, mdc, mdio_oe, mdio_out}), 64'b0001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 R2: write at every range code
    for (int c = 0; c < 16; c++) begin
      txn(c, 1'b1, 5'(c * 3 + 1), 5'(31 - c), 16'(16'h1357 * (c + 1)), 16'h0, 1'b0, 1'b0,
          (c >= 6) ? "R2" : "R1");
    end
    // R5 R6: reads with several data patterns
    txn(8, 1'b0, 5'h01, 5'h02, 16'h0, 16'hA55A, 1'b0, 1'b0, "R2");
    txn(2, 1'b0, 5'h1F, 5'h00, 16'h0, 16'h8001, 1'b0, 1'b0, "R1");
    txn(9, 1'b0, 5'h10, 5'h1F, 16'h0, 16'hFFFF, 1'b0, 1'b0, "R2");
    txn(15, 1'b0, 5'h0A, 5'h15, 16'h0, 16'h0000, 1'b0, 1'b0, "R2");
    txn(0, 1'b0, 5'h05, 5'h0C, 16'h0, 16'h3C96, 1'b0, 1'b0, "R1");
    // R8: command while busy ignored
    txn(8, 1'b1, 5'h12, 5'h07, 16'hBEEF, 16'h0, 1'b1, 1'b0, "R2");
    txn(10, 1'b0, 5'h03, 5'h11, 16'h0, 16'h6A6A, 1'b1, 1'b0, "R2");
    // R10: range change mid-frame
    txn(8, 1'b1, 5'h04, 5'h09, 16'h0F0F, 16'h0, 1'b0, 1'b1, "R10");
    txn(3, 1'b0, 5'h1C, 5'h03, 16'h0, 16'hC3A5, 1'b0, 1'b1, "R10");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule